// File: doc/BRIEF.md
# Card Clock Divider with Stop Controls

This block produces the clock for a memory-card host port from a fast system clock. The division is built in two stages: a power-of-two source prescaler followed by a final divider of 2 or 4. The overall ratio is their product, so the valid totals are 2, 4, 8, 16, 32 and 64. The output `card_clk` is a 50% duty level generated in the system clock domain. A downstream clock-enable or gating cell can use it directly. Each high phase and each low phase lasts half the total ratio in system clock cycles.

A 10-bit control word holds both divider selects and two stop bits. One stop bit gates the card clock. The other gates a high-speed intermediate clock, and that intermediate clock only has to run for the short prescaler settings. The word can be written raw with `cfg_we`. Two command pulses act on the stop bits alone: `off_req` stops everything, and `on_req` restores the stop pattern that belongs to the stored prescaler.

The waveform is generated by a three-state machine with the states STOP, HIGH and LOW:
- STOP to HIGH happens when the card stop bit is clear. The half-period is latched on this transition.
- HIGH to LOW happens at the end of the high phase if the clock is still running.
- HIGH to STOP happens at the end of the high phase if the card stop bit is set.
- LOW to HIGH happens at the end of the low phase, and the half-period is re-latched from the current control word.
- LOW to STOP happens at once when the card stop bit is set.

Top module: `card_clk_div`

## Requirements
- R1: After reset the control word is 0x301: both stop bits are set, the prescaler select is 0 and the final select is 1. `card_clk` and `clk_on` are low.
- R2: Bit 9 is the intermediate-clock stop and bit 8 is the card-clock stop. `card_clk` toggles only while bit 8 is 0. `hs_run` is the inverse of bit 9.
- R3: `clk_on` is high exactly when bits 9 and 8 are both 0.
- R4: The prescaler select sits in bits 4:2. Values 0 to 4 divide by 1, 2, 4, 8 and 16. Values 5 to 7 are reserved and divide by 16.
- R5: The final select sits in bits 1:0. Value 0 divides by 2 and any other value divides by 4. While running, each high phase and each low phase of `card_clk` lasts (prescaler ratio × final ratio)/2 clock cycles.
- R6: `off_req` sets both stop bits and leaves the divider fields unchanged.
- R7: `on_req` clears bit 8. It sets bit 9 when the stored prescaler select is 2 or above, and clears bit 9 for selects 0 and 1. The divider fields are unchanged.
- R8: When requests coincide in a cycle, `off_req` wins over `on_req`, and `on_req` wins over `cfg_we`. The losing requests in that cycle have no effect.
- R9: A divider change made while running takes effect at the next rising edge of `card_clk`. The high and low phases already under way keep the old length.
- R10: When bit 8 becomes set, a high phase in progress completes its full length and a low phase ends at once. `card_clk` then stays low while bit 8 is set.
- R11: When the clock restarts from the stopped state, the first high phase has the full length for the current setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Raw write strobe for the control word |
| cfg_wdata | input | 10 | Control word value to write |
| on_req | input | 1 | Start request; restores the stop pattern for the stored prescaler |
| off_req | input | 1 | Stop request; sets both stop bits |
| ctl_q | output | 10 | Current control word |
| card_clk | output | 1 | Divided card clock level |
| hs_run | output | 1 | High when the intermediate clock may run |
| clk_on | output | 1 | High when both stop bits are clear |

## Verification
The bench sweeps every prescaler and final-select code, including the reserved prescaler codes and final-select values 2 and 3, and measures both phase lengths. A decode that let the reserved codes wrap or grow would show a wrong period there.

A divider change is made in the middle of a long high phase. A design that reloaded the counter at once would cut that phase short instead of waiting for the next rising edge.

Stopping is exercised in both phases. A design that dropped the output mid-high would emit a runt pulse, and one that finished the low phase would return late. Restart is checked for a full first high phase.

The bench also checks the stop pattern that `on_req` writes back for a prescaler select of 2 or above, and the priority between coincident requests. A design that took `clk_on` from bit 8 alone, or let a write slip through alongside a command, would fail there.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int CTL_W         = 10;
    localparam int HS_STOP_BIT   = 9;
    localparam int CARD_STOP_BIT = 8;
    localparam int PRE_LSB       = 2;
    localparam int PRE_W         = 3;
    localparam int FIN_W         = 2;
    localparam logic [CTL_W-1:0] CTL_RESET = 10'h301;

    typedef enum logic [1:0] {
        WV_STOP = 2'd0,
        WV_HIGH = 2'd1,
        WV_LOW  = 2'd2
    } wave_state_t;
endpackage

// File: rtl/ccd_ctl_reg.sv
module ccd_ctl_reg
    import ccd_pkg::*;
#(
    parameter int PRE_HS_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             on_req,
    input  logic             off_req,
    output logic [CTL_W-1:0] ctl_q
);
    logic [PRE_W-1:0] pre_sel;
    assign pre_sel = ctl_q[PRE_LSB +: PRE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (off_req) begin
            ctl_q[HS_STOP_BIT]   <= 1'b1;
            ctl_q[CARD_STOP_BIT] <= 1'b1;
        end else if (on_req) begin
            ctl_q[CARD_STOP_BIT] <= 1'b0;
            ctl_q[HS_STOP_BIT]   <= (int'(pre_sel) >= PRE_HS_MIN);
        end else if (cfg_we) begin
            ctl_q <= cfg_wdata;
        end
    end
endmodule

// File: rtl/ccd_ratio.sv
module ccd_ratio
    import ccd_pkg::*;
#(
    parameter int PRE_MAX_SEL = 4,
    localparam int HALF_W     = PRE_MAX_SEL + 2
) (
    input  logic [PRE_W-1:0]  pre_sel,
    input  logic [FIN_W-1:0]  fin_sel,
    output logic [HALF_W-1:0] half_m1
);
    logic [PRE_W-1:0]  pre_eff;
    logic [HALF_W-1:0] half;

    always_comb begin
        pre_eff = (int'(pre_sel) > PRE_MAX_SEL) ? PRE_W'(PRE_MAX_SEL) : pre_sel;
        half    = HALF_W'(1) << (int'(pre_eff) + ((fin_sel != '0) ? 1 : 0));
        half_m1 = half - HALF_W'(1);
    end
endmodule

// File: rtl/ccd_wave.sv
module ccd_wave
    import ccd_pkg::*;
#(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              card_clk
);
    wave_state_t       state_q, state_n;
    logic [HALF_W-1:0] cnt_q, cnt_n;
    logic [HALF_W-1:0] hold_q, hold_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WV_STOP;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            hold_q  <= hold_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        hold_n  = hold_q;
        unique case (state_q)
            WV_STOP: begin
                if (run) begin
                    state_n = WV_HIGH;
                    cnt_n   = half_m1;
                    hold_n  = half_m1;
                end
            end
            WV_HIGH: begin
                if (cnt_q == '0) begin
                    if (run) begin
                        state_n = WV_LOW;
                        cnt_n   = hold_q;
                    end else begin
                        state_n = WV_STOP;
                    end
                end else begin
                    cnt_n = cnt_q - HALF_W'(1);
                end
            end
            WV_LOW: begin
                if (!run) begin
                    state_n = WV_STOP;
                end else if (cnt_q == '0) begin
                    state_n = WV_HIGH;
                    cnt_n   = half_m1;
                    hold_n  = half_m1;
                end else begin
                    cnt_n = cnt_q - HALF_W'(1);
                end
            end
            default: state_n = WV_STOP;
        endcase
    end

    always_comb begin
        card_clk = (state_q == WV_HIGH);
    end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int PRE_MAX_SEL = 4,
    parameter int PRE_HS_MIN  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [9:0]  cfg_wdata,
    input  logic        on_req,
    input  logic        off_req,
    output logic [9:0]  ctl_q,
    output logic        card_clk,
    output logic        hs_run,
    output logic        clk_on
);
    localparam int HALF_W = PRE_MAX_SEL + 2;

    logic [HALF_W-1:0] half_m1;

    ccd_ctl_reg #(.PRE_HS_MIN(PRE_HS_MIN)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .on_req    (on_req),
        .off_req   (off_req),
        .ctl_q     (ctl_q)
    );

    ccd_ratio #(.PRE_MAX_SEL(PRE_MAX_SEL)) u_ratio (
        .pre_sel (ctl_q[PRE_LSB +: PRE_W]),
        .fin_sel (ctl_q[FIN_W-1:0]),
        .half_m1 (half_m1)
    );

    ccd_wave #(.HALF_W(HALF_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (~ctl_q[CARD_STOP_BIT]),
        .half_m1  (half_m1),
        .card_clk (card_clk)
    );

    assign hs_run = ~ctl_q[HS_STOP_BIT];
    assign clk_on = ~ctl_q[HS_STOP_BIT] & ~ctl_q[CARD_STOP_BIT];
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
    parameter int PRE_MAX_SEL = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       on_req,
    input logic       off_req,
    input logic [9:0] ctl_q,
    input logic       card_clk,
    input logic       clk_on
);
    localparam int HALF_MAX = 1 << (PRE_MAX_SEL + 1);

    logic [7:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_run_q <= '0;
        else if (card_clk) hi_run_q <= (hi_run_q == 8'hff) ? hi_run_q : hi_run_q + 8'd1;
        else               hi_run_q <= '0;
    end

    p_off_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> (ctl_q[9:8] == 2'b11) && !clk_on);

    p_on_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (on_req && !off_req) |=> !ctl_q[8] && (ctl_q[9] == ($past(ctl_q[4:2]) >= 3'd2)));

    p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> !$past(ctl_q[8]));

    p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[8] && !card_clk) |=> !card_clk);

    p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hi_run_q) <= HALF_MAX);
endmodule

bind card_clk_div card_clk_div_chk #(.PRE_MAX_SEL(PRE_MAX_SEL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .on_req   (on_req),
    .off_req  (off_req),
    .ctl_q    (ctl_q),
    .card_clk (card_clk),
    .clk_on   (clk_on)
);

// File: tb/card_clk_div_test.sv
module card_clk_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic       on_req = 1'b0;
    logic       off_req = 1'b0;
    logic [9:0] ctl_q;
    logic       card_clk, hs_run, clk_on;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    card_clk_div uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .on_req(on_req), .off_req(off_req), .ctl_q(ctl_q),
        .card_clk(card_clk), .hs_run(hs_run), .clk_on(clk_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_half(input int pre, input int fin);
        int p = (pre > 4) ? 4 : pre;
        return 1 << (p + ((fin != 0) ? 1 : 0));
    endfunction

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic write_cfg(input logic [9:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit on, input bit off, input bit we, input logic [9:0] v);
        on_req = on; off_req = off; cfg_we = we; cfg_wdata = v;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wait_level(input logic lv);
        for (int i = 0; i < 300; i++) begin
            if (card_clk == lv) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise();
        wait_level(1'b0);
        wait_level(1'b1);
    endtask

    task automatic measure(input logic lv, output int n);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            if (card_clk != lv) return;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int nh, nl, stays;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctl reset", int'(ctl_q), 'h301);
        chk("R1 card_clk reset", int'(card_clk), 0);
        chk("R1 clk_on reset", int'(clk_on), 0);
        repeat (10) @(negedge clk);
        chk("R2 stopped stays low", int'(card_clk), 0);

        // R4 R5 sweep of all prescaler and final codes, stops clear
        for (int pre = 0; pre < 8; pre++) begin
            for (int fin = 0; fin < 4; fin++) begin
                write_cfg(10'((pre << 2) | fin));
                chk("R3 clk_on with stops clear", int'(clk_on), 1);
                wait_level(1'b0);
                wait_rise();
                measure(1'b1, nh);
                measure(1'b0, nl);
                chk($sformatf("R4/R5 high pre%0d fin%0d", pre, fin), nh, exp_half(pre, fin));
                chk($sformatf("R4/R5 low pre%0d fin%0d", pre, fin), nl, exp_half(pre, fin));
            end
        end

        // R2 R3: intermediate stop set, card clock still runs
        write_cfg(10'h200 | 10'((1 << 2) | 0));
        chk("R3 clk_on low with bit9 set", int'(clk_on), 0);
        chk("R2 hs_run low", int'(hs_run), 0);
        wait_level(1'b0);
        wait_rise();
        measure(1'b1, nh);
        chk("R2 runs with bit8 clear", nh, 2);

        // R9: divider change in mid high phase
        write_cfg(10'((4 << 2) | 1));
        wait_level(1'b0);
        wait_rise();
        repeat (5) @(negedge clk);
        write_cfg(10'h000);
        measure(1'b1, nh);
        nh = nh + 6;
        measure(1'b0, nl);
        chk("R9 old high kept", nh, 32);
        chk("R9 old low kept", nl, 32);
        measure(1'b1, nh);
        chk("R9 new high after rise", nh, 1);

        // R10 stop during high phase, R6
        write_cfg(10'((2 << 2) | 0));
        wait_level(1'b0);
        wait_rise();
        @(negedge clk);
        pulse(1'b0, 1'b1, 1'b0, '0);
        chk("R6 stop bits set", int'(ctl_q[9:8]), 3);
        chk("R6 fields kept", int'(ctl_q[4:0]), (2 << 2));
        chk("R6 clk_on low", int'(clk_on), 0);
        measure(1'b1, nh);
        chk("R10 high completes", nh + 2, 4);
        stays = 1;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) stays = 0;
            @(negedge clk);
        end
        chk("R10 held low after stop", stays, 1);

        // R10 stop during low phase
        write_cfg(10'((3 << 2) | 0));
        wait_level(1'b0);
        wait_rise();
        measure(1'b1, nh);
        @(negedge clk);
        pulse(1'b0, 1'b1, 1'b0, '0);
        stays = 1;
        for (int i = 0; i < 40; i++) begin
            if (card_clk) stays = 0;
            @(negedge clk);
        end
        chk("R10 low phase ends at once", stays, 1);

        // R7 R11 restart with prescaler 3
        write_cfg(10'h300 | 10'((3 << 2) | 1));
        pulse(1'b1, 1'b0, 1'b0, '0);
        chk("R7 on pattern pre3", int'(ctl_q), 'h200 | ((3 << 2) | 1));
        chk("R3 clk_on low pre3", int'(clk_on), 0);
        wait_rise();
        measure(1'b1, nh);
        chk("R11 first high full", nh, 16);

        // R7 with prescaler 1
        write_cfg(10'h300 | 10'(1 << 2));
        pulse(1'b1, 1'b0, 1'b0, '0);
        chk("R7 on pattern pre1", int'(ctl_q), (1 << 2));
        chk("R3 clk_on high pre1", int'(clk_on), 1);

        // R8 priority
        pulse(1'b1, 1'b1, 1'b1, 10'h000);
        chk("R8 off beats on and write", int'(ctl_q), 'h300 | (1 << 2));
        pulse(1'b1, 1'b0, 1'b1, 10'((4 << 2) | 0));
        chk("R8 on beats write", int'(ctl_q), (1 << 2));

        finish_run();
    end
endmodule